// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

This block is one 8-bit general-purpose I/O port behind a small APB-style register bus. Software sets a direction for each pin, writes an output value, and reads back the sampled pad levels. Toward the pad cells it drives an output value and an active-low output-enable for each pin. Each pin can also be marked as GPIO or left to an alternate function. Only GPIO pins drive a value or take part in interrupt detection.

Every GPIO pin can raise an interrupt. Each pin has its own polarity and its own choice of level or edge detection. The block turns all of this into one registered, active-high, level-type request for an interrupt controller. Edge events are kept in a sticky status bit until software clears it by writing a one. A chip with several ports instantiates the block once for each port.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every pin is an input: pin_oe_n is all ones, the direction register reads 0xFF, pin_out is 0, irq is 0, and the enable, polarity, mode, status and select registers read 0.
- R2: Direction register bit value 1 means input and 0 means output. pin_oe_n[i] equals direction bit i from the cycle after the write.
- R3: A read of the data register returns the pad levels after a two-flop synchronizer, whatever the direction, and not the value last written.
- R4: pin_out[i] carries data register bit i only when direction bit i is 0 and select bit i is 1. Otherwise it is 0. The data register resets to zero.
- R5: A pin whose select bit is 0 drives no output value, never sets its status bit, and cannot raise irq.
- R6: Polarity bit 1 makes a pin active-low and 0 makes it active-high. With mode bit 0 (level), the status bit equals the qualified active level with no latching, and writing 1 to it has no effect.
- R7: With mode bit 1 (edge), a change of the qualified level from inactive to active sets a sticky status bit. The bit stays set until a 1 is written to it. A set in the same cycle as the clear wins.
- R8: irq is a flop holding the OR over all pins of (status AND interrupt-enable bit). A pending status with its enable bit clear leaves irq at 0.
- R9: The registers sit at byte offsets 0x00 data, 0x04 direction, 0x08 interrupt enable, 0x0C polarity, 0x10 mode, 0x14 status and 0x18 select. Any other address reads 0, and writes to it change nothing.
- R10: After a pad change, irq rises on the third clock edge in level mode and on the fourth clock edge in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe_n | output | 8 | Pad output enables, active low |
| irq | output | 1 | Active-high level interrupt request |

## Verification
Two functions can act on one edge-mode status bit in the same cycle: a new edge sets it, and a software write-one clears it. The bench provokes this by driving a rising pad level exactly two clock edges before the access phase of a status write. The synchronizer delay then lands the set on the same edge as the clear. The status bit is then read back and must still be set; a second write with no new edge must clear it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 5;

  localparam int OFF_DATA = 'h00;
  localparam int OFF_DIR  = 'h04;
  localparam int OFF_IEN  = 'h08;
  localparam int OFF_POL  = 'h0C;
  localparam int OFF_MODE = 'h10;
  localparam int OFF_STAT = 'h14;
  localparam int OFF_FSEL = 'h18;

  typedef enum logic [2:0] {
    REG_DATA, REG_DIR, REG_IEN, REG_POL, REG_MODE, REG_STAT, REG_FSEL, REG_NONE
  } reg_id_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  input  logic [W-1:0]  pin_sync,
  input  logic [W-1:0]  status,
  output logic [W-1:0]  prdata,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  ien_q,
  output logic [W-1:0]  pol_q,
  output logic [W-1:0]  mode_q,
  output logic [W-1:0]  fsel_q,
  output logic [W-1:0]  clr_mask
);
  reg_id_e      sel_id;
  logic         wr_en;
  logic [W-1:0] data_d, dir_d, ien_d, pol_d, mode_d, fsel_d;

  // address decode
  always_comb begin
    if      (paddr == AW'(OFF_DATA)) sel_id = REG_DATA;
    else if (paddr == AW'(OFF_DIR))  sel_id = REG_DIR;
    else if (paddr == AW'(OFF_IEN))  sel_id = REG_IEN;
    else if (paddr == AW'(OFF_POL))  sel_id = REG_POL;
    else if (paddr == AW'(OFF_MODE)) sel_id = REG_MODE;
    else if (paddr == AW'(OFF_STAT)) sel_id = REG_STAT;
    else if (paddr == AW'(OFF_FSEL)) sel_id = REG_FSEL;
    else                             sel_id = REG_NONE;
  end

  assign wr_en = psel & penable & pwrite;

  // next state
  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    ien_d  = ien_q;
    pol_d  = pol_q;
    mode_d = mode_q;
    fsel_d = fsel_q;
    if (wr_en) begin
      case (sel_id)
        REG_DATA: data_d = pwdata;
        REG_DIR:  dir_d  = pwdata;
        REG_IEN:  ien_d  = pwdata;
        REG_POL:  pol_d  = pwdata;
        REG_MODE: mode_d = pwdata;
        REG_FSEL: fsel_d = pwdata;
        default:  ;
      endcase
    end
  end

  assign clr_mask = (wr_en && sel_id == REG_STAT) ? pwdata : '0;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      ien_q  <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      fsel_q <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      pol_q  <= pol_d;
      mode_q <= mode_d;
      fsel_q <= fsel_d;
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel_id)
        REG_DATA: prdata = pin_sync;
        REG_DIR:  prdata = dir_q;
        REG_IEN:  prdata = ien_q;
        REG_POL:  prdata = pol_q;
        REG_MODE: prdata = mode_q;
        REG_STAT: prdata = status;
        REG_FSEL: prdata = fsel_q;
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_cond.sv
module gpio_irq_cond #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] pol_q,
  input  logic [W-1:0] mode_q,
  input  logic [W-1:0] fsel_q,
  input  logic [W-1:0] ien_q,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] act_lvl;
  logic [W-1:0] lvl_q;
  logic [W-1:0] sticky_q, sticky_d;
  logic         irq_q, irq_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    // qualified active level: polarity bit 1 inverts the pad
    assign act_lvl[i]  = (pin_sync[i] ^ pol_q[i]) & fsel_q[i];
    // set beats clear; leaving edge mode drops the sticky bit
    assign sticky_d[i] = mode_q[i] &
                         ((sticky_q[i] & ~clr_mask[i]) | (act_lvl[i] & ~lvl_q[i]));
    assign status[i]   = mode_q[i] ? sticky_q[i] : act_lvl[i];
  end

  assign irq_d = |(status & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      sticky_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      lvl_q    <= act_lvl;
      sticky_q <= sticky_d;
      irq_q    <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  output logic [W-1:0]  prdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe_n,
  output logic          irq
);
  logic         rst_meta_q, rst_sync_n;
  logic [W-1:0] pin_sync;
  logic [W-1:0] status;
  logic [W-1:0] data_q, dir_q, ien_q, pol_q, mode_q, fsel_q, clr_mask;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_sync2 #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_regfile #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .pin_sync (pin_sync),
    .status   (status),
    .prdata   (prdata),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .ien_q    (ien_q),
    .pol_q    (pol_q),
    .mode_q   (mode_q),
    .fsel_q   (fsel_q),
    .clr_mask (clr_mask)
  );

  gpio_irq_cond #(.W(W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_sync (pin_sync),
    .pol_q    (pol_q),
    .mode_q   (mode_q),
    .fsel_q   (fsel_q),
    .ien_q    (ien_q),
    .clr_mask (clr_mask),
    .status   (status),
    .irq      (irq)
  );

  assign pin_oe_n = dir_q;
  assign pin_out  = data_q & ~dir_q & fsel_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [W-1:0]  pwdata,
  input logic [W-1:0]  prdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe_n,
  input logic          irq,
  input logic [W-1:0]  status,
  input logic [W-1:0]  ien_q,
  input logic [W-1:0]  mode_q,
  input logic [W-1:0]  fsel_q,
  input logic [W-1:0]  clr_mask
);
  logic unmapped;
  assign unmapped = (paddr != AW'(OFF_DATA)) && (paddr != AW'(OFF_DIR)) &&
                    (paddr != AW'(OFF_IEN))  && (paddr != AW'(OFF_POL)) &&
                    (paddr != AW'(OFF_MODE)) && (paddr != AW'(OFF_STAT)) &&
                    (paddr != AW'(OFF_FSEL));

  AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == AW'(OFF_DIR)) |=> (pin_oe_n == $past(pwdata))); // R2

  AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & pin_oe_n) == '0)); // R4

  AST_NO_DRIVE_ALT_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~fsel_q) == '0)); // R5

  AST_EDGE_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status & mode_q & ~clr_mask) & mode_q & ~status) == '0)); // R7

  AST_IRQ_FROM_ENABLED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & ien_q)))); // R8

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && unmapped) |-> (prdata == '0)); // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .pin_out  (pin_out),
  .pin_oe_n (pin_oe_n),
  .irq      (irq),
  .status   (status),
  .ien_q    (ien_q),
  .mode_q   (mode_q),
  .fsel_q   (fsel_q),
  .clr_mask (clr_mask)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_IEN = 5'h08, A_POL = 5'h0C,
                         A_MODE = 5'h10, A_STAT = 5'h14, A_FSEL = 5'h18, A_NONE = 5'h1C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [7:0] pwdata = '0;
  logic [7:0] prdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe_n;
  logic       irq;
  int         total = 0;
  int         bad = 0;
  logic [7:0] rd;

  always #2.5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
  );

  // {dir, data, pins, exp_out, exp_oe_n, exp_read}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'hA5, 8'h3C, 8'hA5, 8'h00, 8'h3C},
    {8'hFF, 8'hA5, 8'hC3, 8'h00, 8'hFF, 8'hC3},
    {8'hF0, 8'hFF, 8'h5A, 8'h0F, 8'hF0, 8'h5A},
    {8'h0F, 8'h81, 8'h00, 8'h80, 8'h0F, 8'h00},
    {8'h55, 8'hFF, 8'hFF, 8'hAA, 8'h55, 8'hFF},
    {8'hAA, 8'h0F, 8'h96, 8'h05, 8'hAA, 8'h96}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [7:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    cyc(3); rst_n = 1'b1; cyc(4);

    // R1 reset state
    chk("R1 oe_n", pin_oe_n, 8'hFF);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rdreg(A_DIR, rd);  chk("R1 dir", rd, 8'hFF);
    rdreg(A_FSEL, rd); chk("R1 fsel", rd, 8'h00);
    rdreg(A_IEN, rd);  chk("R1 ien", rd, 8'h00);
    rdreg(A_STAT, rd); chk("R1 status", rd, 8'h00);
    wr(A_DIR, 8'h00);
    chk("R1 data cleared", pin_out, 8'h00);

    // R9 unmapped
    rdreg(A_NONE, rd); chk("R9 unmapped read", rd, 8'h00);
    wr(A_NONE, 8'h3C);
    rdreg(A_DIR, rd);  chk("R9 unmapped write ignored", rd, 8'h00);

    // table: R2 R3 R4
    wr(A_FSEL, 8'hFF);
    for (int v = 0; v < NV; v++) begin
      wr(A_DIR, VEC[v][47:40]);
      wr(A_DATA, VEC[v][39:32]);
      pin_in = VEC[v][31:24];
      cyc(3);
      chk("R4 pin_out", pin_out, VEC[v][23:16]);
      chk("R2 oe_n", pin_oe_n, VEC[v][15:8]);
      rdreg(A_DATA, rd); chk("R3 readback", rd, VEC[v][7:0]);
    end
    wr(A_DIR, 8'hFF);
    pin_in = 8'h00; cyc(4);

    // R6 R10 level, active high
    wr(A_IEN, 8'h01);
    pin_in = 8'h01;
    cyc(2); chk("R10 level irq not before 3 edges", {7'b0, irq}, 8'h00);
    cyc(1); chk("R10 level irq at 3 edges", {7'b0, irq}, 8'h01);
    rdreg(A_STAT, rd); chk("R6 level status", rd, 8'h01);
    wr(A_STAT, 8'h01);
    rdreg(A_STAT, rd); chk("R6 level W1C no effect", rd, 8'h01);
    pin_in = 8'h00; cyc(3);
    chk("R6 level no latch irq", {7'b0, irq}, 8'h00);

    // R6 active-low polarity on pin 1
    wr(A_POL, 8'h02); wr(A_IEN, 8'h02); cyc(3);
    chk("R6 active-low irq", {7'b0, irq}, 8'h01);
    rdreg(A_STAT, rd); chk("R6 active-low status", rd, 8'h02);
    wr(A_IEN, 8'h00); wr(A_POL, 8'h00); cyc(3);

    // R7 R10 edge mode
    wr(A_MODE, 8'h01); wr(A_IEN, 8'h01); cyc(2);
    pin_in = 8'h01;
    cyc(3); chk("R10 edge irq not before 4 edges", {7'b0, irq}, 8'h00);
    cyc(1); chk("R10 edge irq at 4 edges", {7'b0, irq}, 8'h01);
    pin_in = 8'h00; cyc(4);
    rdreg(A_STAT, rd); chk("R7 sticky after pin drops", rd, 8'h01);
    chk("R7 irq held", {7'b0, irq}, 8'h01);
    wr(A_STAT, 8'h01);
    rdreg(A_STAT, rd); chk("R7 W1C clears", rd, 8'h00);
    chk("R7 irq cleared", {7'b0, irq}, 8'h00);

    // R7 set and clear in the same cycle
    pin_in = 8'h01; cyc(1);
    wr(A_STAT, 8'h01);
    rdreg(A_STAT, rd); chk("R7 set wins over clear", rd, 8'h01);
    wr(A_STAT, 8'h01);
    rdreg(A_STAT, rd); chk("R7 later clear", rd, 8'h00);
    pin_in = 8'h00; cyc(3);

    // R8 enable masks request
    wr(A_IEN, 8'h00);
    pin_in = 8'h01; cyc(5);
    rdreg(A_STAT, rd); chk("R8 status pending", rd, 8'h01);
    chk("R8 masked irq", {7'b0, irq}, 8'h00);
    wr(A_IEN, 8'h01); cyc(1);
    chk("R8 enable raises irq", {7'b0, irq}, 8'h01);
    wr(A_STAT, 8'h01); wr(A_IEN, 8'h00); wr(A_MODE, 8'h00);
    pin_in = 8'h00; cyc(3);

    // R5 alternate-function pin
    wr(A_FSEL, 8'hFE); wr(A_IEN, 8'h01);
    wr(A_DIR, 8'h00); wr(A_DATA, 8'hFF);
    pin_in = 8'h01; cyc(4);
    rdreg(A_STAT, rd); chk("R5 no status", rd, 8'h00);
    chk("R5 no irq", {7'b0, irq}, 8'h00);
    chk("R5 no drive", pin_out, 8'hFE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule